// File: doc/BRIEF.md
# Hardware Cursor and Area Detect Generator

This block runs at the pixel clock. It produces two cursor plane bits and two rectangle-detect bits for every pixel. It keeps its own raster coordinates, counting them from the active-low horizontal sync and vertical blank inputs. With the default parameters, the top-left visible pixel is at coordinate (212, 34) and the bottom-right visible pixel is at (1235, 897).

The cursor has two forms:
- a 16-row by 16-bit two-plane sprite;
- a crosshair, either one or two pixels wide, which can be clipped to either of two programmable rectangles.

Each rectangle detector has its own enable bit and its own force bit. A test flag records whether any of the four outputs has been asserted.

Software programs the block through twelve write-only 16-bit registers. All of them are shadowed, and the shadow copy moves into the working set only at the start of vertical blank. The sprite is loaded through one port whose row pointer advances on each write.

Top module: `cursor_gen`

## Requirements
- R1: After reset, all four pixel outputs, the test flag, every shadow and working register, the sprite rows and the load pointer are zero.
- R2: The raster X count is zero while hsyncN is low and increments by one on every clock while hsyncN is high. The Y count is zero while vblankN is low and increments on each falling edge of hsyncN while vblankN is high. Each output is registered one clock after the coordinate it describes.
- R3: A write goes to a shadow copy only. The working set takes the whole shadow on the clock where vblankN is first sampled low. Register addresses are:
  - 0: command
  - 1: X position
  - 2: Y position
  - 3–6: xMin1, xMax1, yMin1, yMax1
  - 7–10: xMin2, xMax2, yMin2, yMax2
  - 11: sprite port
- R4: With its enable bit set, a region output is high exactly when xMin ≤ x ≤ xMax and yMin ≤ y ≤ yMax, with inclusive bounds. The enable bits are command bit 5 for region 1 and bit 3 for region 2.
- R5: A region whose enable bit and force bit are both clear outputs zero, whatever its bounds.
- R6: A region force bit drives that region output high on every pixel and overrides the enable bit. The force bits are command bit 4 for region 1 and bit 2 for region 2.
- R7: Sprite loading works as follows:
  - While the shadow command bit 1 is set, each write to the sprite port stores a row and advances a pointer.
  - The fill order is plane A rows 0–15, then plane B rows 0–15, then back to plane A row 0.
  - Sprite-port writes with that bit clear are ignored.
  - While the working copy of bit 1 is set, the sprite shows nothing.
- R8: A command write that takes bit 1 from one to zero resets the load pointer, so the next load fills plane A row 0.
- R9: In sprite mode (command bit 10 clear), the sprite's top-left pixel sits at the programmed X/Y position. Row bit 15 is the leftmost pixel. Plane A is shown when bit 11 is set, and plane B when bit 12 is set.
- R10: In crosshair mode (bit 10 set), the lines lie at x = X position and y = Y position inside the visible window. When bit 6 is set, each line also covers the next pixel to the right or below.
- R11: With bit 8 set, the crosshair appears only inside the raw bounds of a rectangle: rectangle 1 when bit 7 is one, rectangle 2 when bit 7 is zero. With bit 8 clear, the lines span the whole visible window.
- R12: Command bit 9 drives plane B high on every pixel, overriding every other cursor setting.
- R13: A command write with bit 0 set clears the test flag. Otherwise the flag sets one clock after any of the four outputs is high, and it stays set. A clear takes priority over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncN | input | 1 | Horizontal sync, active low |
| vblankN | input | 1 | Vertical blank, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register index |
| wrData | input | 16 | Write data |
| planeA | output | 1 | Cursor plane A bit |
| planeB | output | 1 | Cursor plane B bit |
| regionOne | output | 1 | Rectangle 1 detect |
| regionTwo | output | 1 | Rectangle 2 detect |
| testFlag | output | 1 | Output-activity test flag |

## Verification
A behavioural model in the bench follows the raster and every output bit on each clock.

The stimulus runs through a series of phases:
- Region bounds are written mid-frame, which shows whether they take effect only after retrace.
- Enable-only, force-only and disabled cases separate the priority of force over enable.
- Narrow, wide, unclipped and both clip choices of the crosshair separate width growth from rectangle selection.
- A 33-row load proves the plane order and the wrap.
- A partial load followed by a toggle of the load bit proves the pointer reset.
- A write with loading off proves that such writes are ignored.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_XPOS = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_YPOS = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_X1LO = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_X1HI = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_Y1LO = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_Y1HI = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_X2LO = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_X2HI = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_Y2LO = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_Y2HI = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_SPR  = 4'd11;

  // command word, bit 0 at the bottom
  typedef struct packed {
    logic [2:0] rsvd;
    logic enB;        // 12
    logic enA;        // 11
    logic crossMode;  // 10
    logic forceB;     // 9
    logic clipOn;     // 8
    logic clipSelR1;  // 7
    logic xhWide;     // 6
    logic rg1En;      // 5
    logic rg1Force;   // 4
    logic rg2En;      // 3
    logic rg2Force;   // 2
    logic spriteLoad; // 1
    logic tstClr;     // 0
  } cmd_t;

  typedef struct packed {
    cmd_t cmd;
    logic [DATA_W-1:0] xPos, yPos;
    logic [DATA_W-1:0] xMin1, xMax1, yMin1, yMax1;
    logic [DATA_W-1:0] xMin2, xMax2, yMin2, yMax2;
  } cfg_t;

  typedef struct packed {
    logic testClr;
    logic retrace;
  } strobe_t;
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int SPR_ROWS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblankN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output cfg_t              actCfg,
  output logic [DATA_W-1:0] actSprA [SPR_ROWS],
  output logic [DATA_W-1:0] actSprB [SPR_ROWS],
  output strobe_t           stb
);
  localparam int ENTRIES = 2 * SPR_ROWS;
  localparam int IDX_W   = $clog2(ENTRIES);

  cfg_t shCfg, nextSh;
  logic vbPrev;
  logic [IDX_W-1:0] sprIdx;
  logic [DATA_W-1:0] shSpr [ENTRIES];
  logic [DATA_W-1:0] actSpr [ENTRIES];
  logic sprWr, loadEnd, cmdWr;

  assign cmdWr = wrEn && (wrAddr == ADR_CMD);

  always_comb begin
    nextSh = shCfg;
    if (wrEn) begin
      case (wrAddr)
        ADR_CMD:  nextSh.cmd   = cmd_t'(wrData);
        ADR_XPOS: nextSh.xPos  = wrData;
        ADR_YPOS: nextSh.yPos  = wrData;
        ADR_X1LO: nextSh.xMin1 = wrData;
        ADR_X1HI: nextSh.xMax1 = wrData;
        ADR_Y1LO: nextSh.yMin1 = wrData;
        ADR_Y1HI: nextSh.yMax1 = wrData;
        ADR_X2LO: nextSh.xMin2 = wrData;
        ADR_X2HI: nextSh.xMax2 = wrData;
        ADR_Y2LO: nextSh.yMin2 = wrData;
        ADR_Y2HI: nextSh.yMax2 = wrData;
        default: ;
      endcase
    end
  end

  assign sprWr   = wrEn && (wrAddr == ADR_SPR) && shCfg.cmd.spriteLoad;
  assign loadEnd = cmdWr && shCfg.cmd.spriteLoad && !nextSh.cmd.spriteLoad;
  assign stb.retrace = vbPrev && !vblankN;
  assign stb.testClr = cmdWr && nextSh.cmd.tstClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shCfg  <= '0;
      actCfg <= '0;
      vbPrev <= 1'b1;
      sprIdx <= '0;
    end else begin
      shCfg  <= nextSh;
      vbPrev <= vblankN;
      if (stb.retrace) actCfg <= shCfg;
      if (loadEnd) sprIdx <= '0;
      else if (sprWr) sprIdx <= sprIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        shSpr[i]  <= '0;
        actSpr[i] <= '0;
      end
    end else begin
      if (stb.retrace)
        for (int i = 0; i < ENTRIES; i++) actSpr[i] <= shSpr[i];
      if (sprWr) shSpr[sprIdx] <= wrData;
    end
  end

  for (genvar g = 0; g < SPR_ROWS; g++) begin : g_rows
    assign actSprA[g] = actSpr[g];
    assign actSprB[g] = actSpr[SPR_ROWS + g];
  end
endmodule

// File: rtl/cursor_dp.sv
module cursor_dp
  import cursor_pkg::*;
#(
  parameter int CW       = 11,
  parameter int VIS_X0   = 212,
  parameter int VIS_X1   = 1235,
  parameter int VIS_Y0   = 34,
  parameter int VIS_Y1   = 897,
  parameter int SPR_ROWS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              vblankN,
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] sprA [SPR_ROWS],
  input  logic [DATA_W-1:0] sprB [SPR_ROWS],
  input  strobe_t           stb,
  output logic              planeA,
  output logic              planeB,
  output logic              regionOne,
  output logic              regionTwo,
  output logic              testFlag
);
  localparam int EW    = DATA_W + 1;
  localparam int RIW   = $clog2(SPR_ROWS);
  localparam int CIW   = $clog2(DATA_W);
  localparam logic [EW-1:0] VisX0 = EW'(VIS_X0);
  localparam logic [EW-1:0] VisX1 = EW'(VIS_X1);
  localparam logic [EW-1:0] VisY0 = EW'(VIS_Y0);
  localparam logic [EW-1:0] VisY1 = EW'(VIS_Y1);

  logic [CW-1:0] xCnt, yCnt;
  logic hsPrev;
  logic [EW-1:0] xe, ye, xp, yp, dx, dy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt <= '0;
      yCnt <= '0;
      hsPrev <= 1'b1;
    end else begin
      hsPrev <= hsyncN;
      xCnt <= hsyncN ? xCnt + 1'b1 : '0;
      if (!vblankN) yCnt <= '0;
      else if (hsPrev && !hsyncN) yCnt <= yCnt + 1'b1;
    end
  end

  assign xe = EW'(xCnt);
  assign ye = EW'(yCnt);
  assign xp = EW'(cfg.xPos);
  assign yp = EW'(cfg.yPos);

  // rectangle detectors
  logic [DATA_W-1:0] rxMin [2], rxMax [2], ryMin [2], ryMax [2];
  logic [1:0] rect, rForce, rEn, regHit;
  assign rxMin[0] = cfg.xMin1; assign rxMax[0] = cfg.xMax1;
  assign ryMin[0] = cfg.yMin1; assign ryMax[0] = cfg.yMax1;
  assign rxMin[1] = cfg.xMin2; assign rxMax[1] = cfg.xMax2;
  assign ryMin[1] = cfg.yMin2; assign ryMax[1] = cfg.yMax2;
  assign rForce = {cfg.cmd.rg2Force, cfg.cmd.rg1Force};
  assign rEn    = {cfg.cmd.rg2En, cfg.cmd.rg1En};

  for (genvar g = 0; g < 2; g++) begin : g_rect
    assign rect[g] = (xe >= EW'(rxMin[g])) && (xe <= EW'(rxMax[g])) &&
                     (ye >= EW'(ryMin[g])) && (ye <= EW'(ryMax[g]));
    assign regHit[g] = rForce[g] | (rEn[g] & rect[g]);
  end

  // crosshair
  logic inVis, onV, onH, clipOk, xh;
  assign inVis  = (xe >= VisX0) && (xe <= VisX1) && (ye >= VisY0) && (ye <= VisY1);
  assign onV    = (xe == xp) || (cfg.cmd.xhWide && (xe == xp + 1'b1));
  assign onH    = (ye == yp) || (cfg.cmd.xhWide && (ye == yp + 1'b1));
  assign clipOk = !cfg.cmd.clipOn || (cfg.cmd.clipSelR1 ? rect[0] : rect[1]);
  assign xh     = (onV || onH) && inVis && clipOk;

  // sprite
  logic sprHit, sprOn, bitA, bitB, pixA, pixB;
  logic [RIW-1:0] rowIdx;
  logic [CIW-1:0] colIdx;
  assign dx = xe - xp;
  assign dy = ye - yp;
  assign sprHit = (xe >= xp) && (dx < EW'(DATA_W)) && (ye >= yp) && (dy < EW'(SPR_ROWS));
  assign rowIdx = dy[RIW-1:0];
  assign colIdx = CIW'(DATA_W - 1) - dx[CIW-1:0];
  assign bitA   = sprA[rowIdx][colIdx];
  assign bitB   = sprB[rowIdx][colIdx];
  assign sprOn  = sprHit && !cfg.cmd.spriteLoad;
  assign pixA   = cfg.cmd.crossMode ? xh : (sprOn & bitA);
  assign pixB   = cfg.cmd.crossMode ? xh : (sprOn & bitB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      planeA <= 1'b0;
      planeB <= 1'b0;
      regionOne <= 1'b0;
      regionTwo <= 1'b0;
      testFlag <= 1'b0;
    end else begin
      planeA    <= cfg.cmd.enA & pixA;
      planeB    <= cfg.cmd.forceB | (cfg.cmd.enB & pixB);
      regionOne <= regHit[0];
      regionTwo <= regHit[1];
      testFlag  <= stb.testClr ? 1'b0
                 : (testFlag | planeA | planeB | regionOne | regionTwo);
    end
  end
endmodule

// File: rtl/cursor_gen.sv
module cursor_gen
  import cursor_pkg::*;
#(
  parameter int CW       = 11,
  parameter int VIS_X0   = 212,
  parameter int VIS_X1   = 1235,
  parameter int VIS_Y0   = 34,
  parameter int VIS_Y1   = 897,
  parameter int SPR_ROWS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsyncN,
  input  logic        vblankN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [15:0] wrData,
  output logic        planeA,
  output logic        planeB,
  output logic        regionOne,
  output logic        regionTwo,
  output logic        testFlag
);
  cfg_t    actCfg;
  strobe_t stb;
  logic [DATA_W-1:0] sprA [SPR_ROWS];
  logic [DATA_W-1:0] sprB [SPR_ROWS];

  cursor_ctrl #(.SPR_ROWS(SPR_ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .vblankN(vblankN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .actCfg(actCfg), .actSprA(sprA), .actSprB(sprB), .stb(stb)
  );

  cursor_dp #(
    .CW(CW), .VIS_X0(VIS_X0), .VIS_X1(VIS_X1),
    .VIS_Y0(VIS_Y0), .VIS_Y1(VIS_Y1), .SPR_ROWS(SPR_ROWS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vblankN(vblankN),
    .cfg(actCfg), .sprA(sprA), .sprB(sprB), .stb(stb),
    .planeA(planeA), .planeB(planeB), .regionOne(regionOne),
    .regionTwo(regionTwo), .testFlag(testFlag)
  );
endmodule

// File: rtl/cursor_gen_chk.sv
module cursor_gen_chk
  import cursor_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    vblankN,
  input cfg_t    actCfg,
  input strobe_t stb,
  input logic    planeA,
  input logic    planeB,
  input logic    regionOne,
  input logic    regionTwo,
  input logic    testFlag
);
  // R3: working set only moves on a vblank falling edge
  a_r3_hold_until_retrace: assert property (@(posedge clk) disable iff (!rstN)
    (vblankN || !$past(vblankN)) |=> $stable(actCfg));

  // R5: disabled, unforced region stays low
  a_r5_region_off: assert property (@(posedge clk) disable iff (!rstN)
    (!actCfg.cmd.rg1Force && !actCfg.cmd.rg1En) |=> !regionOne);

  // R6: force wins
  a_r6_region_forced: assert property (@(posedge clk) disable iff (!rstN)
    actCfg.cmd.rg2Force |=> regionTwo);

  // R7: loading hides the sprite
  a_r7_load_hides: assert property (@(posedge clk) disable iff (!rstN)
    (!actCfg.cmd.crossMode && actCfg.cmd.spriteLoad) |=> !planeA);

  // R12: plane B forced high
  a_r12_force_b: assert property (@(posedge clk) disable iff (!rstN)
    actCfg.cmd.forceB |=> planeB);

  // R13: clear strobe empties the flag
  a_r13_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.testClr |=> !testFlag);
endmodule

bind cursor_gen cursor_gen_chk u_chk (.*);

// File: tb/cursor_gen_tb.sv
module cursor_gen_tb;
  localparam int VX0 = 6, VX1 = 40, VY0 = 3, VY1 = 27;
  localparam int LINE = 48, SYNC = 4, LINES = 32, BLANK = 2;

  logic clk = 1'b0, rstN = 1'b0, hsyncN = 1'b1, vblankN = 1'b1, wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic planeA, planeB, regionOne, regionTwo, testFlag;

  cursor_gen #(.VIS_X0(VX0), .VIS_X1(VX1), .VIS_Y0(VY0), .VIS_Y1(VY1)) u_dut (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vblankN(vblankN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .planeA(planeA), .planeB(planeB), .regionOne(regionOne),
    .regionTwo(regionTwo), .testFlag(testFlag)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string req = "R1";
  bit cmpOn = 0, finished = 0;

  // reference model state
  int sh [12], act [12];
  int shSpr [32], actSpr [32];
  int idx = 0, mx = 0, my = 0, hsP = 1, vbP = 1;
  int oA = 0, oB = 0, o1 = 0, o2 = 0, oT = 0;

  function automatic int bt(int v, int b);
    return (v >> b) & 1;
  endfunction

  function automatic int inR(int x, int y, int base);
    return (x >= act[base] && x <= act[base+1] && y >= act[base+2] && y <= act[base+3]) ? 1 : 0;
  endfunction

  task automatic pixel(input int x, input int y, output int a, output int b,
                       output int r1, output int r2);
    int c, xh, sA, sB, vis, on, clip, dx, dy;
    c = act[0];
    r1 = (bt(c,4) || (bt(c,5) && inR(x,y,3))) ? 1 : 0;
    r2 = (bt(c,2) || (bt(c,3) && inR(x,y,7))) ? 1 : 0;
    vis = (x >= VX0 && x <= VX1 && y >= VY0 && y <= VY1) ? 1 : 0;
    on = (x == act[1] || y == act[2] ||
          (bt(c,6) && (x == act[1]+1 || y == act[2]+1))) ? 1 : 0;
    clip = !bt(c,8) ? 1 : (bt(c,7) ? inR(x,y,3) : inR(x,y,7));
    xh = on & vis & clip;
    dx = x - act[1]; dy = y - act[2];
    sA = 0; sB = 0;
    if (!bt(c,1) && dx >= 0 && dx < 16 && dy >= 0 && dy < 16) begin
      sA = bt(actSpr[dy], 15 - dx);
      sB = bt(actSpr[16 + dy], 15 - dx);
    end
    a = bt(c,11) & (bt(c,10) ? xh : sA);
    b = bt(c,9) | (bt(c,12) & (bt(c,10) ? xh : sB));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      for (int i = 0; i < 12; i++) begin sh[i] = 0; act[i] = 0; end
      for (int i = 0; i < 32; i++) begin shSpr[i] = 0; actSpr[i] = 0; end
      idx = 0; mx = 0; my = 0; hsP = 1; vbP = 1;
      oA = 0; oB = 0; o1 = 0; o2 = 0; oT = 0;
    end else begin
      int na, nb, n1, n2;
      pixel(mx, my, na, nb, n1, n2);
      if (wrEn && wrAddr == 0 && wrData[0]) oT = 0;
      else oT = oT | oA | oB | o1 | o2;
      oA = na; oB = nb; o1 = n1; o2 = n2;
      if (vbP && !vblankN) begin
        act = sh;
        actSpr = shSpr;
      end
      if (wrEn) begin
        if (wrAddr == 0) begin
          if (bt(sh[0],1) && !wrData[1]) idx = 0;
          sh[0] = int'(wrData);
        end else if (wrAddr <= 10) sh[wrAddr] = int'(wrData);
        else if (wrAddr == 11 && bt(sh[0],1)) begin
          shSpr[idx] = int'(wrData);
          idx = (idx + 1) % 32;
        end
      end
      mx = hsyncN ? mx + 1 : 0;
      if (!vblankN) my = 0;
      else if (hsP && !hsyncN) my = my + 1;
      hsP = hsyncN; vbP = vblankN;
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog req=%s got=hung expected=done", req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      logic [4:0] got, exp;
      got = {planeA, planeB, regionOne, regionTwo, testFlag};
      exp = {oA[0], oB[0], o1[0], o2[0], oT[0]};
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s at x=%0d y=%0d got=%b expected=%b", req, mx, my, got, exp);
      end
    end
  end

  // raster driver
  initial begin
    forever begin
      for (int ln = 0; ln < LINES; ln++) begin
        for (int px = 0; px < LINE; px++) begin
          @(negedge clk);
          vblankN = (ln >= BLANK);
          hsyncN  = (px >= SYNC);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic frames(input int n);
    repeat (n) @(negedge vblankN);
    @(negedge clk);
  endtask

  task automatic spot(input string r, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s spot got=%b expected=%b", r, got, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cmpOn = 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    req = "R1";
    spot("R1", planeA | planeB | regionOne | regionTwo | testFlag, 1'b0);
    frames(1);

    req = "R2";
    frames(1);

    // R3: bounds and enable written mid-frame, visible only after retrace
    req = "R3";
    wr(3, 10); wr(4, 20); wr(5, 5); wr(6, 12);
    wr(0, 16'h0020);
    spot("R3", regionOne, 1'b0);
    frames(2);

    req = "R4";
    wr(7, 25); wr(8, 30); wr(9, 15); wr(10, 25);
    wr(0, 16'h0028);
    frames(2);

    req = "R5";
    wr(0, 16'h0008);
    frames(2);

    req = "R6";
    wr(0, 16'h0014);
    frames(2);

    req = "R10";
    wr(1, 20); wr(2, 10);
    wr(0, 16'h1C00);
    frames(2);
    wr(0, 16'h1C40);
    frames(2);

    req = "R11";
    wr(0, 16'h1DC0);
    frames(2);
    wr(0, 16'h1D00);
    frames(2);

    // R7: 33 loads wrap onto plane A row 0, then loading off
    req = "R7";
    wr(0, 16'h0002);
    for (int i = 0; i < 33; i++) wr(11, ((i * 947) ^ 49153) & 65535);
    wr(0, 16'h1800);
    wr(11, 16'hFFFF);
    wr(1, 12); wr(2, 6);
    frames(2);

    req = "R9";
    wr(1, 30); wr(2, 20);
    frames(2);

    // R8: partial load, toggle load bit, next row lands in plane A row 0
    req = "R8";
    wr(0, 16'h0002);
    wr(11, 16'h1234); wr(11, 16'h5678); wr(11, 16'h9ABC);
    wr(0, 16'h0000);
    wr(0, 16'h0002);
    wr(11, 16'hF00F);
    wr(0, 16'h1800);
    wr(1, 8); wr(2, 4);
    frames(2);

    req = "R12";
    wr(0, 16'h0200);
    frames(2);

    // R13: quiet frame, clear, then activity sets it again
    req = "R13";
    wr(0, 16'h0000);
    frames(2);
    wr(0, 16'h0001);
    @(negedge clk);
    spot("R13", testFlag, 1'b0);
    frames(1);
    spot("R13", testFlag, 1'b0);
    wr(0, 16'h0010);
    frames(2);
    spot("R13", testFlag, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule